// File: doc/BRIEF.md
# Receive-Enable Delay Setting Accumulator

This block holds one receive-enable delay setting as a mixed-radix number with four digits: a coarse clock count, a phase digit that only ever moves by two, a tap digit and a fine digit. The radix of the tap and fine digits depends on the speed mode. Calibration logic outside the block sends it one step command at a time. Each step adds to or subtracts from one or two digits. The block then carries or borrows between the digits until every digit is back inside its radix. While that runs it holds off further commands, and when it finishes it shows the normalized digits. A coarse count that ends up outside its legal range raises a sticky error.

A load pulse starts a new search. It sets the coarse count to the CAS latency plus one, clears the other digits and the error, and captures the speed mode used by every later step. A command that needs no carry completes in the cycle it is accepted. Each carry or borrow adds one cycle per digit level it has to cross.

Top module: `rx_delay_accum`

## Requirements
- R1: After reset, coarse, phase, tap and fine all read 0, err is 0, and out_valid, cmd_ready and !busy are all 1.
- R2: A load pulse has priority over everything else, including a normalization in progress. It sets coarse to cas_lat+1, sets phase, tap and fine to 0, clears err, and latches fast_mode as the radix mode. Changing fast_mode later has no effect until the next load.
- R3: When the latched mode is 1, the tap radix T is 9 and the fine radix P is 8. When it is 0, T is 12 and P is 1. Whenever out_valid is 1, tap<T, fine<P and phase is 0 or 2.
- R4: The command codes on cmd_op are: 0 subtracts 1 from coarse; 1 subtracts 2 from phase; 4 adds 1 to fine; 5 adds 2 to tap. Codes 6 and 7 are accepted and leave the setting unchanged.
- R5: Code 2 adds floor(T/2) to tap and (T mod 2)*floor(P/2) to fine. Code 3 subtracts the same two amounts.
- R6: Normalization carries and borrows digit to digit: each full radix of fine moves one unit into tap, each full radix of tap moves 2 into phase, and each 4 of phase moves one unit into coarse. The total value is preserved, so the final digits equal the unique in-range representation.
- R7: out_valid is the inverse of busy. While busy is 1, the setting changes on every cycle. A command whose result is already in range leaves busy at 0. One that needs carries finishes within 6 cycles.
- R8: cmd_ready is 1 only when busy is 0 and err is 0. A cmd_valid pulse while cmd_ready is 0 has no effect on the setting.
- R9: If the normalized coarse count lies outside 0..15, err goes to 1 and stays at 1 until the next load. While err is 1, commands are refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | Speed mode sampled on load (1 selects T=9, P=8) |
| load | input | 1 | Start a new setting from cas_lat |
| cas_lat | input | CASW | CAS latency used by load |
| cmd_valid | input | 1 | Step command present |
| cmd_op | input | 3 | Step command code |
| cmd_ready | output | 1 | Command will be accepted this cycle |
| busy | output | 1 | Normalization in progress |
| out_valid | output | 1 | Digits are normalized |
| coarse | output | CW | Coarse clock count |
| phase | output | 2 | Phase digit (0 or 2) |
| tap | output | TW | Tap digit |
| fine | output | FW | Fine digit |
| err | output | 1 | Sticky coarse range error |

## Verification
The bench uses the default parameters: a 4-bit coarse count and the two radix pairs 9/8 and 12/1. With these, the whole coarse range and both speed modes can be swept. For every mode and every CAS latency from 0 to 15, the bench runs a pseudo-random walk over all eight command codes. It flips fast_mode after each load, and it compares every settled digit with an integer model that normalizes the same way. The walks reach long carry chains, borrows past zero, and both ends of the coarse range. Directed cases cover the single-cycle busy window that a fine carry opens in the slow mode, a command offered during that window, and error entry at each end of the coarse range.

// File: rtl/rx_delay_accum.sv
module rx_delay_accum #(
  parameter int CW        = 4,
  parameter int CASW      = 4,
  parameter int FAST_TAPS = 9,
  parameter int FAST_FINE = 8,
  parameter int SLOW_TAPS = 12,
  parameter int SLOW_FINE = 1,
  localparam int TMAX = (FAST_TAPS > SLOW_TAPS) ? FAST_TAPS : SLOW_TAPS,
  localparam int PMAX = (FAST_FINE > SLOW_FINE) ? FAST_FINE : SLOW_FINE,
  localparam int TW   = (TMAX > 2) ? $clog2(TMAX) : 1,
  localparam int FW   = (PMAX > 2) ? $clog2(PMAX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fast_mode,
  input  logic            load,
  input  logic [CASW-1:0] cas_lat,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  output logic            cmd_ready,
  output logic            busy,
  output logic            out_valid,
  output logic [CW-1:0]   coarse,
  output logic [1:0]      phase,
  output logic [TW-1:0]   tap,
  output logic [FW-1:0]   fine,
  output logic            err
);
  localparam int WW = 8;
  localparam int CMAX = (1 << CW) - 1;
  localparam logic signed [WW-1:0] ZERO = '0;
  localparam logic signed [WW-1:0] ONE  = WW'(1);
  localparam logic signed [WW-1:0] TWO  = WW'(2);
  localparam logic signed [WW-1:0] FOUR = WW'(4);
  localparam logic signed [WW-1:0] CLIM = WW'(CMAX);

  logic signed [WW-1:0] c_q, h_q, t_q, f_q;
  logic                 mode_q, err_q;

  logic signed [WW-1:0] tb, pb, qt, qf;
  assign tb = mode_q ? WW'(FAST_TAPS) : WW'(SLOW_TAPS);
  assign pb = mode_q ? WW'(FAST_FINE) : WW'(SLOW_FINE);
  assign qt = tb >>> 1;
  assign qf = tb[0] ? (pb >>> 1) : ZERO;

  logic f_lo, f_hi, t_lo, t_hi, h_lo, h_hi, c_bad;
  assign f_lo  = f_q < ZERO;
  assign f_hi  = f_q >= pb;
  assign t_lo  = t_q < ZERO;
  assign t_hi  = t_q >= tb;
  assign h_lo  = h_q < ZERO;
  assign h_hi  = h_q >= FOUR;
  assign c_bad = (c_q < ZERO) || (c_q > CLIM);

  assign busy      = f_lo | f_hi | t_lo | t_hi | h_lo | h_hi;
  assign out_valid = ~busy;
  assign err       = err_q | (~busy & c_bad);
  assign cmd_ready = ~busy & ~err;

  logic take;
  assign take = cmd_valid & cmd_ready;

  logic signed [WW-1:0] f_nrm, t_nrm, h_nrm, c_nrm;
  assign f_nrm = f_q + (f_lo ? pb : ZERO) - (f_hi ? pb : ZERO);
  assign t_nrm = t_q + (f_hi ? ONE : ZERO) - (f_lo ? ONE : ZERO)
                     + (t_lo ? tb : ZERO) - (t_hi ? tb : ZERO);
  assign h_nrm = h_q + (t_hi ? TWO : ZERO) - (t_lo ? TWO : ZERO)
                     + (h_lo ? FOUR : ZERO) - (h_hi ? FOUR : ZERO);
  assign c_nrm = c_q + (h_hi ? ONE : ZERO) - (h_lo ? ONE : ZERO);

  logic signed [WW-1:0] dc, dh, dt, df;
  always_comb begin
    dc = ZERO; dh = ZERO; dt = ZERO; df = ZERO;
    case (cmd_op)
      3'd0: dc = -ONE;
      3'd1: dh = -TWO;
      3'd2: begin dt = qt;  df = qf;  end
      3'd3: begin dt = -qt; df = -qf; end
      3'd4: df = ONE;
      3'd5: dt = TWO;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q <= ZERO; h_q <= ZERO; t_q <= ZERO; f_q <= ZERO;
      mode_q <= 1'b0; err_q <= 1'b0;
    end else if (load) begin
      c_q <= $signed(WW'(cas_lat)) + ONE;
      h_q <= ZERO; t_q <= ZERO; f_q <= ZERO;
      mode_q <= fast_mode;
      err_q  <= 1'b0;
    end else begin
      err_q <= err;
      if (busy) begin
        c_q <= c_nrm; h_q <= h_nrm; t_q <= t_nrm; f_q <= f_nrm;
      end else if (take) begin
        c_q <= c_q + dc; h_q <= h_q + dh; t_q <= t_q + dt; f_q <= f_q + df;
      end
    end
  end

  assign coarse = c_q[CW-1:0];
  assign phase  = h_q[1:0];
  assign tap    = t_q[TW-1:0];
  assign fine   = f_q[FW-1:0];

  a_r3_phase_even: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (h_q[0] == 1'b0));

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (c_q == $signed(WW'($past(cas_lat))) + ONE) && h_q == ZERO
             && t_q == ZERO && f_q == ZERO && !err_q);

  a_r7_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> !$stable({c_q, h_q, t_q, f_q}));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take && !load) |=> $stable({c_q, h_q, t_q, f_q}));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !load) |=> err);

  a_r6_coarse_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (c_q - $past(c_q) <= ONE) && ($past(c_q) - c_q <= ONE));
endmodule

// File: tb/rx_delay_accum_test.sv
module rx_delay_accum_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, fast_mode = 1'b0, load = 1'b0;
  logic [3:0] cas_lat = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic cmd_ready, busy, out_valid, err;
  logic [3:0] coarse, tap;
  logic [1:0] phase;
  logic [2:0] fine;

  rx_delay_accum uut (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .load(load),
    .cas_lat(cas_lat), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .busy(busy), .out_valid(out_valid),
    .coarse(coarse), .phase(phase), .tap(tap), .fine(fine), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int mc, mh, mt, mf, mT, mP, merr;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_norm();
    while (mf >= mP) begin mt++; mf -= mP; end
    while (mf < 0)   begin mt--; mf += mP; end
    while (mt >= mT) begin mh += 2; mt -= mT; end
    while (mt < 0)   begin mh -= 2; mt += mT; end
    while (mh >= 4)  begin mc++; mh -= 4; end
    while (mh < 0)   begin mc--; mh += 4; end
    if (mc < 0 || mc > 15) merr = 1;
  endtask

  task automatic model_op(input int op);
    case (op)
      0: mc--;
      1: mh -= 2;
      2: begin mt += mT / 2; mf += (mT % 2) * (mP / 2); end
      3: begin mt -= mT / 2; mf -= (mT % 2) * (mP / 2); end
      4: mf++;
      5: mt += 2;
      default: ;
    endcase
    model_norm();
  endtask

  task automatic do_load(input int cas, input bit fm);
    @(negedge clk);
    load = 1'b1; cas_lat = 4'(cas); fast_mode = fm;
    @(negedge clk);
    load = 1'b0; fast_mode = ~fm;
    mc = cas + 1; mh = 0; mt = 0; mf = 0; merr = 0;
    mT = fm ? 9 : 12; mP = fm ? 8 : 1;
    if (mc > 15) merr = 1;
  endtask

  task automatic compare(input string req);
    chk(err == 1'(merr), {req, " err"}, int'(err), merr);
    if (!merr) begin
      chk(int'(coarse) == mc, {req, " coarse"}, int'(coarse), mc);
      chk(int'(phase) == mh, {req, " phase"}, int'(phase), mh);
      chk(int'(tap) == mt, {req, " tap"}, int'(tap), mt);
      chk(int'(fine) == mf, {req, " fine"}, int'(fine), mf);
      chk(int'(tap) < mT && int'(fine) < mP, "R3 range", int'(tap), mT);
    end
  endtask

  task automatic issue(input int op, output int lat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 20) begin
      chk(!cmd_ready, "R8 ready while busy", int'(cmd_ready), 0);
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(coarse == 0 && phase == 0 && tap == 0 && fine == 0, "R1 fields", int'(coarse), 0);
    chk(!err && out_valid && cmd_ready && !busy, "R1 flags", int'(err), 0);

    // R7 slow mode fine carry: exactly one busy cycle
    do_load(3, 1'b0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4;
    @(negedge clk);
    cmd_op = 3'd0;
    chk(busy == 1'b1, "R7 busy after carry step", int'(busy), 1);
    chk(cmd_ready == 1'b0, "R8 ready low while busy", int'(cmd_ready), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b0 && out_valid, "R7 done one cycle later", int'(busy), 0);
    @(negedge clk);
    // R8 held-off full backstep had no effect
    model_op(4);
    compare("R8 held-off command");

    // R4 no-op codes 6 and 7
    issue(6, lat); model_op(6); compare("R4 code6");
    issue(7, lat); model_op(7); compare("R4 code7");
    chk(lat == 0, "R7 no-carry latency", lat, 0);

    // R9 error at top and bottom, sticky, commands refused
    do_load(15, 1'b1);
    chk(err == 1'b1 && !cmd_ready, "R9 load overflow", int'(err), 1);
    issue(0, lat);
    chk(err == 1'b1, "R9 sticky", int'(err), 1);
    do_load(0, 1'b1);
    chk(err == 1'b0 && coarse == 1, "R2 load clears err", int'(coarse), 1);
    issue(0, lat); model_op(0); compare("R4 backstep");
    issue(0, lat); model_op(0); compare("R9 underflow");
    issue(4, lat);
    chk(err == 1'b1, "R9 refused keeps err", int'(err), 1);

    // R2 R5 R6 sweep over modes and CAS latencies
    for (int m = 0; m < 2; m++) begin
      for (int cas = 0; cas < 16; cas++) begin
        do_load(cas, 1'(m));
        compare("R2 load");
        for (int k = 0; k < 40 && !merr; k++) begin
          int op;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          op = int'(lfsr[2:0]);
          issue(op, lat);
          model_op(op);
          chk(lat <= 6, "R7 latency bound", lat, 6);
          compare("R6 sweep");
        end
        if (merr) chk(!cmd_ready, "R9 ready low", int'(cmd_ready), 0);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule